// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A character is offered on a valid/ready handshake together with its format. The format gives a data length of 5 to 8 bits, a parity mode of none, even or odd, and either one or two stop bits. Once the block accepts the character, it drives a low start bit, then the data bits least significant bit first, then the parity bit if one is selected, and finally the stop bits at the high level. When no frame is being sent, the line rests high.

Bit timing comes from an external 16x enable pulse. Every bit of the frame lasts exactly sixteen of those pulses, and clock cycles without a pulse do not advance the frame. The format and the data are captured when the character is accepted, so the surrounding logic may change them while a frame is in flight. A busy flag and a shift-register-empty flag tell the surrounding logic when the line is free again.

Top module: `async_char_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, ser_out is 1, in_ready is 1, busy is 0 and shift_empty is 1.
- R2: A character is accepted on a rising clock edge where in_valid and in_ready are both 1. The start bit (ser_out = 0) begins on that same edge, and busy is 1 from then on.
- R3: After the start bit, the data bits follow least significant bit first. The number of data bits is 5 + cfg_len, so cfg_len values 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Upper bits of in_data beyond that length are not sent.
- R4: cfg_par selects the parity: 2'b00 and 2'b11 give no parity bit. 2'b01 gives even parity, where the parity bit makes the count of ones over the data bits plus parity even. 2'b10 gives odd parity, where that count is odd. The parity bit directly follows the last data bit.
- R5: The frame ends with one stop bit at level 1 when cfg_two_stop is 0, and with two stop bits when it is 1. A 7-bit even-parity frame with one stop bit therefore lasts 10 bit times.
- R6: Every bit of the frame lasts exactly 16 clock cycles in which tick_16x is 1. Cycles with tick_16x at 0 neither advance nor end the frame. A tick that arrives on the accepting edge is not counted.
- R7: in_data, cfg_len, cfg_par and cfg_two_stop are sampled only on the accepting edge. Changing them during a frame does not alter that frame.
- R8: in_ready is 0 while a frame is in progress, and in_valid is ignored during that time. The frame in flight and the frame that follows are unaffected.
- R9: busy falls and shift_empty, in_ready and the idle line level return on the edge that consumes the 16th tick of the last stop bit. shift_empty is always the inverse of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Enable pulse at 16 times the bit rate |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The block can accept a character (idle) |
| in_data | input | DATA_W (8) | Character, LSB sent first |
| cfg_len | input | 2 | Data length select: 5 + cfg_len bits |
| cfg_par | input | 2 | Parity select: 00 none, 01 even, 10 odd, 11 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| ser_out | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is in progress |
| shift_empty | output | 1 | The last stop bit has completed |

## Verification
A wrong bit counter or tick counter in this block shows up on ser_out as a bit held for the wrong number of ticks. It also shows as a frame whose busy flag drops early or late, and the bench sees that within one bit time, at the first bit boundary that differs. A wrong shift or format capture shows as a wrong line level at the middle of some bit of the same frame. A stale ready or busy flag either corrupts the next frame or stalls it, and the bench notices that within the next sixteen ticks. Every frame length and parity combination is swept, once with a tick on every cycle and once with gaps between ticks.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_NONE2 = 2'b11
  } par_mode_e;

  localparam int LEN_SEL_W = 2;
  localparam int MIN_DATA  = 5;
endpackage

// File: rtl/sertx_frame_pack.sv
module sertx_frame_pack
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEFT_W  = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]    data,
  input  logic [LEN_SEL_W-1:0] len_sel,
  input  logic [1:0]           par_sel,
  input  logic                 two_stop,
  output logic [FRAME_W-1:0]   frame,
  output logic [LEFT_W-1:0]    nbits
);
  int   n_data;
  logic has_par;
  logic par_bit;

  always_comb begin
    n_data  = MIN_DATA + int'(len_sel);
    has_par = (par_sel == PAR_EVEN) || (par_sel == PAR_ODD);
    par_bit = (par_sel == PAR_ODD);
    frame   = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n_data) begin
        frame[1+i] = data[i];
        par_bit    = par_bit ^ data[i];
      end
    end
    if (has_par) frame[1+n_data] = par_bit;
    nbits = LEFT_W'(2 + n_data + int'(has_par) + int'(two_stop));
  end
endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
  parameter int OVERSAMPLE = 16,
  parameter int CNT_W      = $clog2(OVERSAMPLE)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == CNT_W'(OVERSAMPLE - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_end = run && tick && (cnt_q == CNT_W'(OVERSAMPLE - 1));

  // R6
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clear && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_16x,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [LEN_SEL_W-1:0] cfg_len,
  input  logic [1:0]           cfg_par,
  input  logic                 cfg_two_stop,
  output logic                 ser_out,
  output logic                 busy,
  output logic                 shift_empty
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] new_frame;
  logic [LEFT_W-1:0]  new_nbits;
  logic [FRAME_W-1:0] shift_q;
  logic [LEFT_W-1:0]  left_q;
  logic               busy_q;
  logic               empty_q;
  logic               line_q;
  logic               accept;
  logic               bit_end;

  assign accept = in_valid && !busy_q;

  sertx_frame_pack #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .LEFT_W (LEFT_W)
  ) pack_i (
    .data    (in_data),
    .len_sel (cfg_len),
    .par_sel (cfg_par),
    .two_stop(cfg_two_stop),
    .frame   (new_frame),
    .nbits   (new_nbits)
  );

  sertx_bit_timer #(
    .OVERSAMPLE(OVERSAMPLE)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .run    (busy_q),
    .tick   (tick_16x),
    .bit_end(bit_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      empty_q <= 1'b1;
      line_q  <= 1'b1;
      shift_q <= '1;
      left_q  <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      empty_q <= 1'b0;
      line_q  <= new_frame[0];
      shift_q <= {1'b1, new_frame[FRAME_W-1:1]};
      left_q  <= new_nbits - 1'b1;
    end else if (bit_end) begin
      if (left_q == '0) begin
        busy_q  <= 1'b0;
        empty_q <= 1'b1;
        line_q  <= 1'b1;
      end else begin
        line_q  <= shift_q[0];
        shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
        left_q  <= left_q - 1'b1;
      end
    end
  end

  assign in_ready    = !busy_q;
  assign busy        = busy_q;
  assign shift_empty = empty_q;
  assign ser_out     = line_q;

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> line_q);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!ser_out && busy));
  // R6
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick_16x) |=> $stable(ser_out));
  // R8
  no_reaccept_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !bit_end) |=> (busy_q && $stable(left_q)));
  // R9
  flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q != empty_q);
  // R9
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (line_q && $past(left_q) == '0));
endmodule

// File: tb/async_char_tx_tb_top.sv
module async_char_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick_16x;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic [1:0] cfg_len;
  logic [1:0] cfg_par;
  logic       cfg_two_stop;
  logic       ser_out;
  logic       busy;
  logic       shift_empty;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_char_tx dut_i (
    .clk(clk), .rst(rst), .tick_16x(tick_16x),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
    .ser_out(ser_out), .busy(busy), .shift_empty(shift_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input logic [7:0] d, input int len, input int par,
                      input int two, input int mode, input bit junk);
    logic [11:0] fr;
    int n, nb, t;
    bit p, tk;
    n = 5 + len;
    fr = '1;
    fr[0] = 1'b0;
    p = (par == 2);
    for (int i = 0; i < n; i++) begin
      fr[1+i] = d[i];
      p = p ^ d[i];
    end
    nb = 2 + n + two;
    if (par == 1 || par == 2) begin
      fr[1+n] = p;
      nb++;
    end
    @(negedge clk);
    chk("R1 ready before accept", int'(in_ready), 1);
    in_valid = 1'b1;
    in_data = d;
    cfg_len = 2'(len);
    cfg_par = 2'(par);
    cfg_two_stop = 1'(two);
    tick_16x = 1'b1;
    @(negedge clk);
    // R7: scramble the inputs; R8: keep offering junk
    in_valid = junk;
    in_data = ~d;
    cfg_len = 2'(len + 1);
    cfg_par = 2'(par + 2);
    cfg_two_stop = 1'(!two);
    t = 0;
    for (;;) begin
      if (t < 16 * nb) begin
        chk("R3 R4 R5 R7 line level", int'(ser_out), int'(fr[t/16]));
        chk("R8 ready low in frame", int'(in_ready), 0);
        chk("R9 busy in frame", int'(busy), 1);
      end else begin
        chk("R9 line idle at end", int'(ser_out), 1);
        chk("R9 busy cleared at end", int'(busy), 0);
        chk("R9 empty set at end", int'(shift_empty), 1);
        chk("R9 ready back at end", int'(in_ready), 1);
        break;
      end
      if (t % 16 == 8) chk("R9 empty low in frame", int'(shift_empty), 0);
      tk = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      tick_16x = tk;
      if (t >= 16 * nb - 2) in_valid = 1'b0;
      if (tk) t++;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1;
    tick_16x = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    cfg_len = 2'd0;
    cfg_par = 2'd0;
    cfg_two_stop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset line", int'(ser_out), 1);
    chk("R1 reset ready", int'(in_ready), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset empty", int'(shift_empty), 1);
    // R6: idle with ticks does not start anything
    tick_16x = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 idle ticks", int'(ser_out), 1);
    chk("R1 idle busy", int'(busy), 0);
    // R5 R4: 7-bit even parity, one stop, char 0x66
    send(8'h66, 2, 1, 0, 0, 1'b0);
    // R2: sweep of all formats, two tick patterns, several characters
    for (int mode = 0; mode < 2; mode++)
      for (int len = 0; len < 4; len++)
        for (int par = 0; par < 4; par++)
          for (int two = 0; two < 2; two++)
            for (int k = 0; k < 3; k++)
              send(8'((len * 37 + par * 11 + two * 5 + k * 91 + mode) ^ 8'hA5),
                   len, par, two, mode, (k != 0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule